// File: doc/BRIEF.md
# Guarded Asymmetric Barrel Shifter

This block is the shift stage of a 40-bit fixed-point datapath. Each cycle it can take one operand from one of three places: a 16-bit data-memory word, accumulator A or accumulator B. It moves that operand left by up to 31 places or right by up to 16 places, as one operation. The top eight bits of the 40-bit word are guard bits above a 32-bit working field. An arithmetic shift treats the whole 40-bit word as a signed value. A logical shift works only on the 32-bit field and clears the guard bits.

A signed shift count selects the direction: a positive count shifts left and a negative count shifts right. The block saturates any count beyond the supported range to the nearest limit and flags it. A destination select sends the result either to the ALU operand port as a full 40-bit word or to the memory store port as one 16-bit half of the 32-bit field. All results are registered, so the block presents its output one clock after the request.

Top module: `guarded_shifter`

## Requirements
- R1: While rst_n is low, and at the first sampling after it is released, alu_valid, st_valid and cnt_clamped are 0, alu_operand is all zeros and st_word is all zeros.
- R2: src_sel selects the operand: 0 selects the memory word, 1 selects acc_a, 2 selects acc_b, and 3 selects a constant zero.
- R3: A memory operand sits in bits 15:0. Bits 39:16 are copies of mem_word[15] when mem_sext is 1, and zeros when mem_sext is 0.
- R4: A shift_cnt from 0 to +31, read as a 6-bit two's complement value, shifts the operand left by that many places. Zeros enter at bit 0 and bits moved past bit 39 are lost.
- R5: With arith = 1, a shift_cnt from -1 to -16 shifts the 40-bit operand right by the count's magnitude, copying bit 39 into the vacated top bits.
- R6: With arith = 0, the shift acts on bits 31:0 only. A right shift fills the vacated bits with zeros, and result bits 39:32 are always 0.
- R7: A shift_cnt below -16 (6'h20 to 6'h2F) is treated as -16, and cnt_clamped is 1 alongside that result. For any other accepted count, cnt_clamped is 0.
- R8: dest = 0 sends the result to alu_operand and raises alu_valid. dest = 1 sends it to st_word and raises st_valid. The output not chosen keeps its previous value.
- R9: For a store, store_hi = 1 puts result bits 31:16 on st_word, and store_hi = 0 puts bits 15:0.
- R10: A request with in_valid = 1 produces its result one clock edge later. In a cycle after in_valid = 0, alu_valid, st_valid and cnt_clamped are 0 and both data outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A shift request is present this cycle |
| src_sel | input | 2 | Operand source: 0 memory, 1 acc A, 2 acc B, 3 zero |
| mem_word | input | 16 | Data-memory word |
| mem_sext | input | 1 | 1 sign-extends the memory word, 0 zero-extends it |
| acc_a | input | 40 | Accumulator A |
| acc_b | input | 40 | Accumulator B |
| shift_cnt | input | 6 | Signed count: positive left, negative right |
| arith | input | 1 | 1 arithmetic shift, 0 logical shift |
| dest | input | 1 | 0 ALU operand port, 1 store port |
| store_hi | input | 1 | For stores, 1 selects bits 31:16 and 0 selects bits 15:0 |
| alu_valid | output | 1 | alu_operand holds a new result |
| alu_operand | output | 40 | Shifted result for the ALU |
| st_valid | output | 1 | st_word holds a new result |
| st_word | output | 16 | Selected half of the shifted result for the store path |
| cnt_clamped | output | 1 | The current result's count was saturated |

## Verification
There is one register between the request inputs and every output, so each result, valid strobe and clamp flag is due exactly one rising edge after the cycle in which in_valid was high. The bench drives each request on a falling edge and drops in_valid on the following falling edge. It then compares the outputs at that same falling edge, after the single intervening rising edge. Hold behaviour and the low strobes are checked at the next falling edge, when the design has seen a cycle with in_valid low. Expected results come from a behavioural model written directly from the requirements, not from the staged shifter structure.

// File: rtl/gbs_pkg.sv
package gbs_pkg;

    localparam int GBS_DATA_W = 40;
    localparam int GBS_LOW_W  = 32;
    localparam int GBS_MEM_W  = 16;
    localparam int GBS_CNT_W  = 6;
    localparam int GBS_LEFT_LIMIT  = 31;
    localparam int GBS_RIGHT_LIMIT = 16;

    typedef enum logic [1:0] {
        SRC_MEM   = 2'd0,
        SRC_ACC_A = 2'd1,
        SRC_ACC_B = 2'd2,
        SRC_ZERO  = 2'd3
    } src_e;

    typedef enum logic {
        DST_ALU   = 1'b0,
        DST_STORE = 1'b1
    } dst_e;

endpackage

// File: rtl/gbs_src_sel.sv
module gbs_src_sel
    import gbs_pkg::*;
#(
    parameter int DATA_W = GBS_DATA_W,
    parameter int MEM_W  = GBS_MEM_W
) (
    input  logic [1:0]        sel,
    input  logic [MEM_W-1:0]  mem_word,
    input  logic              mem_sext,
    input  logic [DATA_W-1:0] acc_a,
    input  logic [DATA_W-1:0] acc_b,
    output logic [DATA_W-1:0] operand
);
    localparam int EXT_W = DATA_W - MEM_W;

    logic [DATA_W-1:0] mem_ext;
    logic              ext_bit;

    always_comb begin
        ext_bit = mem_sext & mem_word[MEM_W-1];
        mem_ext = {{EXT_W{ext_bit}}, mem_word};
    end

    always_comb begin
        unique case (src_e'(sel))
            SRC_MEM:   operand = mem_ext;
            SRC_ACC_A: operand = acc_a;
            SRC_ACC_B: operand = acc_b;
            default:   operand = '0;
        endcase
    end
endmodule

// File: rtl/gbs_cnt_guard.sv
module gbs_cnt_guard
    import gbs_pkg::*;
#(
    parameter int CNT_W       = GBS_CNT_W,
    parameter int LEFT_LIMIT  = GBS_LEFT_LIMIT,
    parameter int RIGHT_LIMIT = GBS_RIGHT_LIMIT,
    parameter int AMT_W       = 5
) (
    input  logic [CNT_W-1:0] cnt,
    output logic             go_left,
    output logic [AMT_W-1:0] amount,
    output logic             clamped
);
    localparam logic signed [CNT_W:0] HI_LIM = (CNT_W+1)'(LEFT_LIMIT);
    localparam logic signed [CNT_W:0] LO_LIM = -((CNT_W+1)'(RIGHT_LIMIT));

    logic signed [CNT_W:0] wide_cnt;
    logic signed [CNT_W:0] bounded;
    logic signed [CNT_W:0] magnitude;

    always_comb begin
        wide_cnt = {cnt[CNT_W-1], cnt};
        bounded  = wide_cnt;
        clamped  = 1'b0;
        if (wide_cnt > HI_LIM) begin
            bounded = HI_LIM;
            clamped = 1'b1;
        end else if (wide_cnt < LO_LIM) begin
            bounded = LO_LIM;
            clamped = 1'b1;
        end
        go_left   = ~bounded[CNT_W];
        magnitude = bounded[CNT_W] ? -bounded : bounded;
        amount    = AMT_W'(magnitude);
    end
endmodule

// File: rtl/gbs_shift_core.sv
module gbs_shift_core
    import gbs_pkg::*;
#(
    parameter int DATA_W = GBS_DATA_W,
    parameter int LOW_W  = GBS_LOW_W,
    parameter int AMT_W  = 5
) (
    input  logic [DATA_W-1:0] operand,
    input  logic              go_left,
    input  logic [AMT_W-1:0]  amount,
    input  logic              arith,
    output logic [DATA_W-1:0] result
);
    localparam int GUARD_W = DATA_W - LOW_W;

    logic              fill_bit;
    logic [DATA_W-1:0] right_in;
    logic [DATA_W-1:0] lstage [AMT_W+1];
    logic [DATA_W-1:0] rstage [AMT_W+1];
    logic [DATA_W-1:0] chosen;

    always_comb begin
        fill_bit = arith & operand[DATA_W-1];
        right_in = arith ? operand : {{GUARD_W{1'b0}}, operand[LOW_W-1:0]};
    end

    assign lstage[0] = operand;
    assign rstage[0] = right_in;

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        if (STEP < DATA_W) begin : g_live
            assign lstage[k+1] = amount[k] ? {lstage[k][DATA_W-STEP-1:0], {STEP{1'b0}}}
                                           : lstage[k];
            assign rstage[k+1] = amount[k] ? {{STEP{fill_bit}}, rstage[k][DATA_W-1:STEP]}
                                           : rstage[k];
        end else begin : g_flush
            assign lstage[k+1] = amount[k] ? '0 : lstage[k];
            assign rstage[k+1] = amount[k] ? {DATA_W{fill_bit}} : rstage[k];
        end
    end

    always_comb begin
        chosen = go_left ? lstage[AMT_W] : rstage[AMT_W];
        result = chosen;
        if (!arith) begin
            result[DATA_W-1:LOW_W] = '0;
        end
    end
endmodule

// File: rtl/guarded_shifter.sv
module guarded_shifter
    import gbs_pkg::*;
#(
    parameter int DATA_W      = GBS_DATA_W,
    parameter int LOW_W       = GBS_LOW_W,
    parameter int MEM_W       = GBS_MEM_W,
    parameter int CNT_W       = GBS_CNT_W,
    parameter int LEFT_LIMIT  = GBS_LEFT_LIMIT,
    parameter int RIGHT_LIMIT = GBS_RIGHT_LIMIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        src_sel,
    input  logic [MEM_W-1:0]  mem_word,
    input  logic              mem_sext,
    input  logic [DATA_W-1:0] acc_a,
    input  logic [DATA_W-1:0] acc_b,
    input  logic [CNT_W-1:0]  shift_cnt,
    input  logic              arith,
    input  logic              dest,
    input  logic              store_hi,
    output logic              alu_valid,
    output logic [DATA_W-1:0] alu_operand,
    output logic              st_valid,
    output logic [MEM_W-1:0]  st_word,
    output logic              cnt_clamped
);
    localparam int MAX_SHIFT = (LEFT_LIMIT > RIGHT_LIMIT) ? LEFT_LIMIT : RIGHT_LIMIT;
    localparam int AMT_W     = $clog2(MAX_SHIFT + 1);

    typedef struct packed {
        logic              alu_valid;
        logic [DATA_W-1:0] alu_operand;
        logic              st_valid;
        logic [MEM_W-1:0]  st_word;
        logic              clamped;
    } out_state_t;

    logic [DATA_W-1:0] operand;
    logic              go_left;
    logic [AMT_W-1:0]  amount;
    logic              clamp_hit;
    logic [DATA_W-1:0] shifted;
    logic [MEM_W-1:0]  store_half;

    out_state_t st_d, st_q;

    gbs_src_sel #(
        .DATA_W (DATA_W),
        .MEM_W  (MEM_W)
    ) u_src (
        .sel      (src_sel),
        .mem_word (mem_word),
        .mem_sext (mem_sext),
        .acc_a    (acc_a),
        .acc_b    (acc_b),
        .operand  (operand)
    );

    gbs_cnt_guard #(
        .CNT_W       (CNT_W),
        .LEFT_LIMIT  (LEFT_LIMIT),
        .RIGHT_LIMIT (RIGHT_LIMIT),
        .AMT_W       (AMT_W)
    ) u_cnt (
        .cnt     (shift_cnt),
        .go_left (go_left),
        .amount  (amount),
        .clamped (clamp_hit)
    );

    gbs_shift_core #(
        .DATA_W (DATA_W),
        .LOW_W  (LOW_W),
        .AMT_W  (AMT_W)
    ) u_core (
        .operand (operand),
        .go_left (go_left),
        .amount  (amount),
        .arith   (arith),
        .result  (shifted)
    );

    always_comb begin
        store_half = store_hi ? shifted[LOW_W-1:LOW_W-MEM_W] : shifted[MEM_W-1:0];
    end

    always_comb begin
        st_d           = st_q;
        st_d.alu_valid = 1'b0;
        st_d.st_valid  = 1'b0;
        st_d.clamped   = 1'b0;
        if (in_valid) begin
            st_d.clamped = clamp_hit;
            if (dst_e'(dest) == DST_ALU) begin
                st_d.alu_valid   = 1'b1;
                st_d.alu_operand = shifted;
            end else begin
                st_d.st_valid = 1'b1;
                st_d.st_word  = store_half;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alu_valid   = st_q.alu_valid;
    assign alu_operand = st_q.alu_operand;
    assign st_valid    = st_q.st_valid;
    assign st_word     = st_q.st_word;
    assign cnt_clamped = st_q.clamped;
endmodule

// File: rtl/gbs_checker.sv
module gbs_checker #(
    parameter int DATA_W = 40,
    parameter int LOW_W  = 32,
    parameter int MEM_W  = 16,
    parameter int CNT_W  = 6,
    parameter int RIGHT_LIMIT = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        src_sel,
    input logic [DATA_W-1:0] acc_a,
    input logic [CNT_W-1:0]  shift_cnt,
    input logic              arith,
    input logic              dest,
    input logic              alu_valid,
    input logic [DATA_W-1:0] alu_operand,
    input logic              st_valid,
    input logic [MEM_W-1:0]  st_word,
    input logic              cnt_clamped
);
    localparam int NEG_LIM = -RIGHT_LIMIT;

    // R2
    acc_a_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_sel == 2'd1 && shift_cnt == '0 && arith && !dest)
        |=> (alu_operand == $past(acc_a)));

    // R6
    guard_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !arith && !dest) |=> (alu_operand[DATA_W-1:LOW_W] == '0));

    // R7
    clamp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ($signed(shift_cnt) < NEG_LIM)) |=> cnt_clamped);

    // R7
    no_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ($signed(shift_cnt) >= NEG_LIM)) |=> !cnt_clamped);

    // R8
    alu_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dest) |=> (alu_valid && !st_valid && $stable(st_word)));

    // R8
    store_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dest) |=> (st_valid && !alu_valid && $stable(alu_operand)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!alu_valid && !st_valid && !cnt_clamped
                       && $stable(alu_operand) && $stable(st_word)));
endmodule

bind guarded_shifter gbs_checker #(
    .DATA_W      (DATA_W),
    .LOW_W       (LOW_W),
    .MEM_W       (MEM_W),
    .CNT_W       (CNT_W),
    .RIGHT_LIMIT (RIGHT_LIMIT)
) u_gbs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .src_sel     (src_sel),
    .acc_a       (acc_a),
    .shift_cnt   (shift_cnt),
    .arith       (arith),
    .dest        (dest),
    .alu_valid   (alu_valid),
    .alu_operand (alu_operand),
    .st_valid    (st_valid),
    .st_word     (st_word),
    .cnt_clamped (cnt_clamped)
);

// File: tb/guarded_shifter_bench.sv
module guarded_shifter_bench;
    localparam int NVEC = 20;
    localparam logic [39:0] ACC_A_VAL = 40'hF1_2345_6789;
    localparam logic [39:0] ACC_B_VAL = 40'h00_8000_0001;

    // {src[2], mem[16], sext, cnt[6], arith, dest, store_hi}
    localparam logic [27:0] VEC [NVEC] = '{
        {2'd1, 16'h0000, 1'b0, 6'h00, 1'b1, 1'b0, 1'b0},
        {2'd2, 16'h0000, 1'b0, 6'h04, 1'b1, 1'b0, 1'b0},
        {2'd1, 16'h0000, 1'b0, 6'h1F, 1'b1, 1'b0, 1'b0},
        {2'd1, 16'h0000, 1'b0, 6'h3C, 1'b1, 1'b0, 1'b0},
        {2'd1, 16'h0000, 1'b0, 6'h30, 1'b1, 1'b0, 1'b0},
        {2'd2, 16'h0000, 1'b0, 6'h3F, 1'b1, 1'b0, 1'b0},
        {2'd1, 16'h0000, 1'b0, 6'h38, 1'b0, 1'b0, 1'b0},
        {2'd1, 16'h0000, 1'b0, 6'h08, 1'b0, 1'b0, 1'b0},
        {2'd0, 16'h8001, 1'b1, 6'h00, 1'b1, 1'b0, 1'b0},
        {2'd0, 16'h8001, 1'b0, 6'h00, 1'b1, 1'b0, 1'b0},
        {2'd0, 16'hC000, 1'b1, 6'h3E, 1'b1, 1'b0, 1'b0},
        {2'd0, 16'h1234, 1'b1, 6'h10, 1'b1, 1'b1, 1'b1},
        {2'd0, 16'h1234, 1'b1, 6'h10, 1'b1, 1'b1, 1'b0},
        {2'd1, 16'h0000, 1'b0, 6'h3C, 1'b1, 1'b1, 1'b1},
        {2'd1, 16'h0000, 1'b0, 6'h20, 1'b1, 1'b0, 1'b0},
        {2'd1, 16'h0000, 1'b0, 6'h2F, 1'b0, 1'b0, 1'b0},
        {2'd3, 16'hFFFF, 1'b1, 6'h05, 1'b1, 1'b0, 1'b0},
        {2'd2, 16'h0000, 1'b0, 6'h01, 1'b1, 1'b1, 1'b1},
        {2'd1, 16'h0000, 1'b0, 6'h3F, 1'b0, 1'b1, 1'b1},
        {2'd0, 16'hFFFF, 1'b1, 6'h30, 1'b0, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  src_sel = '0;
    logic [15:0] mem_word = '0;
    logic        mem_sext = 1'b0;
    logic [39:0] acc_a = ACC_A_VAL;
    logic [39:0] acc_b = ACC_B_VAL;
    logic [5:0]  shift_cnt = '0;
    logic        arith = 1'b0;
    logic        dest = 1'b0;
    logic        store_hi = 1'b0;
    logic        alu_valid;
    logic [39:0] alu_operand;
    logic        st_valid;
    logic [15:0] st_word;
    logic        cnt_clamped;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    guarded_shifter u_guarded_shifter (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .src_sel     (src_sel),
        .mem_word    (mem_word),
        .mem_sext    (mem_sext),
        .acc_a       (acc_a),
        .acc_b       (acc_b),
        .shift_cnt   (shift_cnt),
        .arith       (arith),
        .dest        (dest),
        .store_hi    (store_hi),
        .alu_valid   (alu_valid),
        .alu_operand (alu_operand),
        .st_valid    (st_valid),
        .st_word     (st_word),
        .cnt_clamped (cnt_clamped)
    );

    function automatic logic [39:0] model(input logic [1:0] s, input logic [15:0] m,
                                          input logic sx, input logic [5:0] c,
                                          input logic ar);
        logic [39:0] opd;
        logic [39:0] r;
        int n;
        case (s)
            2'd0: opd = sx ? {{24{m[15]}}, m} : {24'h0, m};
            2'd1: opd = ACC_A_VAL;
            2'd2: opd = ACC_B_VAL;
            default: opd = '0;
        endcase
        n = int'($signed(c));
        if (n < -16) n = -16;
        if (n >= 0)      r = opd << n;
        else if (ar)     r = 40'($signed(opd) >>> (-n));
        else             r = {8'h00, opd[31:0] >> (-n)};
        if (!ar) r[39:32] = 8'h00;
        return r;
    endfunction

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [27:0] v);
        @(negedge clk);
        {src_sel, mem_word, mem_sext, shift_cnt, arith, dest, store_hi} = v;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [39:0] exp;
        logic [39:0] held_alu;
        logic [15:0] held_st;
        string tag;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 alu_valid", {39'b0, alu_valid}, 40'd0);
        check("R1 st_valid", {39'b0, st_valid}, 40'd0);
        check("R1 cnt_clamped", {39'b0, cnt_clamped}, 40'd0);
        check("R1 alu_operand", alu_operand, 40'd0);
        check("R1 st_word", {24'b0, st_word}, 40'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {37'b0, alu_valid, st_valid, cnt_clamped}, 40'd0);

        for (int i = 0; i < NVEC; i++) begin
            logic [27:0] v;
            logic [1:0]  s;
            logic [5:0]  c;
            logic        ar, dst, hi;
            v = VEC[i];
            s = v[27:26]; c = v[8:3]; ar = v[2]; dst = v[1]; hi = v[0];
            held_alu = alu_operand;
            held_st  = st_word;
            issue(v);
            exp = model(s, v[25:10], v[9], c, ar);
            if (s == 2'd3)                  tag = "R2";
            else if (s == 2'd0)             tag = "R3";
            else if ($signed(c) < -16)      tag = "R7";
            else if (!ar)                   tag = "R6";
            else if ($signed(c) < 0)        tag = "R5";
            else                            tag = "R4";
            // R10: result due one edge after the request
            if (!dst) begin
                check({tag, " alu_operand"}, alu_operand, exp);
                check("R8 alu strobe", {38'b0, alu_valid, st_valid}, 40'd2);
                check("R8 store held", {24'b0, st_word}, {24'b0, held_st});
            end else begin
                // R9: store half select
                check({"R9 ", tag, " st_word"}, {24'b0, st_word},
                      {24'b0, hi ? exp[31:16] : exp[15:0]});
                check("R8 store strobe", {38'b0, alu_valid, st_valid}, 40'd1);
                check("R8 alu held", alu_operand, held_alu);
            end
            check("R7 clamp flag", {39'b0, cnt_clamped},
                  {39'b0, ($signed(c) < -16)});
        end

        // R10: idle cycle keeps data, drops strobes
        held_alu = alu_operand;
        held_st  = st_word;
        @(negedge clk);
        check("R10 idle strobes", {37'b0, alu_valid, st_valid, cnt_clamped}, 40'd0);
        check("R10 idle alu hold", alu_operand, held_alu);
        check("R10 idle store hold", {24'b0, st_word}, {24'b0, held_st});

        // R10: back-to-back requests each appear one edge later
        @(negedge clk);
        {src_sel, shift_cnt, arith, dest} = {2'd1, 6'h01, 1'b1, 1'b0};
        in_valid = 1'b1;
        @(negedge clk);
        check("R10 first of pair", alu_operand, model(2'd1, 16'h0, 1'b0, 6'h01, 1'b1));
        {src_sel, shift_cnt} = {2'd2, 6'h3F};
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 second of pair", alu_operand, model(2'd2, 16'h0, 1'b0, 6'h3F, 1'b1));

        // R1: reset clears outputs after activity
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reassert", alu_operand, 40'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule